// File: doc/BRIEF.md
# Debounced Resistor-Code Key Classifier

This block sits behind an external converter that turns the voltage on a remote-control sense line into an 8-bit code. On each sample strobe it classifies the code into one of 32 symbols: a key number, "jack inserted" or "jack removed". Codes that fall between the accepted windows are invalid. A change of class must persist over several consecutive samples before the block treats it as real. This rejects brief chatter. The new symbol must then stay put for a fixed number of millisecond ticks before it is accepted.

Each accepted change produces a one-cycle event that carries the symbol. A key release is a return to the jack-inserted or open-circuit symbol, and it is reported like any other change. A parameter selects one of two encodings. The wide one has 30 keys in windows over the full 8-bit range. The narrow one has 6 keys in the low 3 bits of the code. A synchronous shutdown input holds the block in its reset state.

Top module: `key_classifier`

## Requirements
- R1: With KEYS=30, a code inside a window gives that window's symbol. Key n is symbol n. Examples: 0..1 give key 0, 11..13 key 1, 27..30 key 3, and 235..237 key 29. Codes 243..245 give jack inserted, which is symbol 30. Codes 254..255 give jack removed, which is symbol 31.
- R2: A code outside every window is invalid and never produces an event, however long it is held.
- R3: The event for a new symbol is issued on the clock edge that registers the STABLE_MS-th ms_tick after the symbol passed the chatter filter. It is never issued earlier.
- R4: A run of differing samples shorter than CHATTER_SAMPLES consecutive strobes is discarded. It does not restart or disturb the stability count of the current symbol.
- R5: A filtered invalid code clears the stability count and leaves the last accepted symbol unchanged. Returning afterwards to the accepted symbol produces no event. Returning to a different symbol restarts the full interval.
- R6: A return to the jack-inserted symbol (a key release) is reported as an event with code 30.
- R7: With KEYS=6, only code bits 2:0 matter. Values 0..5 give keys 0..5, 6 gives symbol 30 and 7 gives symbol 31. Every code is valid.
- R8: While shutdown is high the block is held in its reset state and emits no event.
- R9: The first stable symbol after reset or shutdown is always reported, even if it matches the symbol accepted before.
- R10: event_valid is high for exactly one cycle per accepted change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Synchronous hold-in-reset |
| sample | input | 1 | Strobe: code is valid this cycle |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| code | input | 8 | Converter result |
| event_valid | output | 1 | One-cycle event strobe |
| event_code | output | 5 | Accepted symbol (key n = n, 30 inserted, 31 removed) |

## Verification
The hardest behaviour to reach is a chatter burst landing in the middle of a stability interval that is already running. The question is whether the event still comes on the original tick count. The stimulus gets there in three steps. It first lets ten ticks elapse on a key. It then strobes a competing code for one sample fewer than the filter length and returns to the key. Finally it counts the remaining ticks one by one. A similar sequence goes through an invalid code, both back to the accepted symbol and to a new one. This separates clearing the count from changing the accepted symbol.

// File: rtl/key_classifier.sv
module key_classifier #(
  parameter int KEYS            = 30,
  parameter int CHATTER_SAMPLES = 4,
  parameter int STABLE_MS       = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shutdown,
  input  logic       sample,
  input  logic       ms_tick,
  input  logic [7:0] code,
  output logic       event_valid,
  output logic [4:0] event_code
);
  localparam int CW = $clog2(CHATTER_SAMPLES + 1);
  localparam int TW = $clog2(STABLE_MS + 1);

  logic       raw_ok;
  logic [4:0] raw_sym;

  generate
    if (KEYS == 6) begin : g_six
      always_comb begin
        raw_ok = 1'b1;
        case (code[2:0])
          3'd6:    raw_sym = 5'd30;
          3'd7:    raw_sym = 5'd31;
          default: raw_sym = {2'b00, code[2:0]};
        endcase
      end
    end else begin : g_thirty
      function automatic logic [15:0] win(input int i);
        case (i)
          0: win = {8'd0, 8'd1};       1: win = {8'd11, 8'd13};
          2: win = {8'd19, 8'd21};     3: win = {8'd27, 8'd30};
          4: win = {8'd35, 8'd38};     5: win = {8'd42, 8'd46};
          6: win = {8'd50, 8'd53};     7: win = {8'd58, 8'd62};
          8: win = {8'd66, 8'd70};     9: win = {8'd74, 8'd78};
          10: win = {8'd82, 8'd86};    11: win = {8'd90, 8'd94};
          12: win = {8'd98, 8'd102};   13: win = {8'd105, 8'd110};
          14: win = {8'd114, 8'd119};  15: win = {8'd123, 8'd127};
          16: win = {8'd130, 8'd135};  17: win = {8'd137, 8'd142};
          18: win = {8'd146, 8'd150};  19: win = {8'd154, 8'd159};
          20: win = {8'd162, 8'd166};  21: win = {8'd170, 8'd174};
          22: win = {8'd178, 8'd182};  23: win = {8'd186, 8'd190};
          24: win = {8'd194, 8'd198};  25: win = {8'd202, 8'd206};
          26: win = {8'd211, 8'd214};  27: win = {8'd218, 8'd222};
          28: win = {8'd226, 8'd229};  29: win = {8'd235, 8'd237};
          30: win = {8'd243, 8'd245};  default: win = {8'd254, 8'd255};
        endcase
      endfunction

      always_comb begin
        raw_ok  = 1'b0;
        raw_sym = 5'd0;
        for (int i = 0; i < 32; i++) begin
          if (code >= win(i)[15:8] && code <= win(i)[7:0]) begin
            raw_ok  = 1'b1;
            raw_sym = 5'(i);
          end
        end
      end
    end
  endgenerate

  logic          filt_ok, run_ok, acc_ok;
  logic [4:0]    filt_sym, run_sym, acc_sym;
  logic [CW-1:0] run_cnt;
  logic [TW-1:0] tcnt;

  wire same_filt = (raw_ok == filt_ok) && (!raw_ok || raw_sym == filt_sym);
  wire same_run  = (run_cnt != '0) && (raw_ok == run_ok) && (!raw_ok || raw_sym == run_sym);
  wire [CW:0] run_len = same_run ? ({1'b0, run_cnt} + 1'b1) : (CW+1)'(1);
  wire take = sample && !same_filt && (run_len >= (CW+1)'(CHATTER_SAMPLES));
  wire need = filt_ok && (!acc_ok || filt_sym != acc_sym);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_ok <= 1'b0; filt_sym <= '0;
      run_ok  <= 1'b0; run_sym  <= '0; run_cnt <= '0;
      acc_ok  <= 1'b0; acc_sym  <= '0; tcnt    <= '0;
      event_valid <= 1'b0; event_code <= '0;
    end else if (shutdown) begin
      filt_ok <= 1'b0; filt_sym <= '0;
      run_ok  <= 1'b0; run_sym  <= '0; run_cnt <= '0;
      acc_ok  <= 1'b0; acc_sym  <= '0; tcnt    <= '0;
      event_valid <= 1'b0; event_code <= '0;
    end else begin
      event_valid <= 1'b0;
      if (sample) begin
        if (same_filt || take) begin
          run_cnt <= '0;
        end else begin
          run_ok  <= raw_ok;
          run_sym <= raw_sym;
          run_cnt <= CW'(run_len);
        end
      end
      if (take) begin
        filt_ok  <= raw_ok;
        filt_sym <= raw_sym;
        tcnt     <= '0;
      end else if (ms_tick && need) begin
        if (tcnt == TW'(STABLE_MS - 1)) begin
          event_valid <= 1'b1;
          event_code  <= filt_sym;
          acc_ok      <= 1'b1;
          acc_sym     <= filt_sym;
          tcnt        <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/key_classifier_chk.sv
module key_classifier_chk #(
  parameter int KEYS = 30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       shutdown,
  input logic       ms_tick,
  input logic       event_valid,
  input logic [4:0] event_code
);
  AST_ONE_CYCLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    event_valid |=> !event_valid); // R10
  AST_SHDN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !event_valid); // R8
  AST_EVENT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    event_valid |-> $past(ms_tick)); // R3
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (event_valid && KEYS == 6) |-> (event_code < 5'd6 || event_code >= 5'd30)); // R7
endmodule

bind key_classifier key_classifier_chk #(.KEYS(KEYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .ms_tick(ms_tick),
  .event_valid(event_valid), .event_code(event_code)
);

// File: tb/sim_key_classifier.sv
module sim_key_classifier;
  localparam int PERIOD = 10;
  localparam int CH = 4;
  localparam int ST = 18;

  logic clk = 1'b0, rst_n = 1'b0, shutdown = 1'b0, sample = 1'b0, ms_tick = 1'b0;
  logic [7:0] code = 8'd100;
  logic ev0, ev1;
  logic [4:0] c0, c1;

  key_classifier #(.KEYS(30), .CHATTER_SAMPLES(CH), .STABLE_MS(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .sample(sample), .ms_tick(ms_tick),
    .code(code), .event_valid(ev0), .event_code(c0));
  key_classifier #(.KEYS(6), .CHATTER_SAMPLES(CH), .STABLE_MS(ST)) u1 (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .sample(sample), .ms_tick(ms_tick),
    .code(code), .event_valid(ev1), .event_code(c1));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int n0 = 0, n1 = 0;
  logic [4:0] last0 = '0, last1 = '0;

  always @(posedge clk) begin
    #1;
    if (ev0) begin n0++; last0 = c0; end
    if (ev1) begin n1++; last1 = c1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic samp(input logic [7:0] v);
    @(negedge clk); code = v; sample = 1'b1;
    @(negedge clk); sample = 1'b0;
  endtask

  task automatic settle(input logic [7:0] v);
    for (int i = 0; i < CH; i++) samp(v);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic key_event(input logic [7:0] v, input int exp, input string req);
    int b = n0;
    settle(v);
    ticks(ST - 1);
    chk(n0 == b, req, n0 - b, 0);
    ticks(1);
    chk(n0 == b + 1 && last0 == 5'(exp), req, int'(last0), exp);
  endtask

  task automatic t_reset;
    chk(ev0 == 1'b0 && n0 == 0, "R8", int'(ev0), 0);
  endtask

  task automatic t_first;
    key_event(8'd244, 30, "R9");
  endtask

  task automatic t_pulse;
    int b = n0;
    settle(8'd12);
    ticks(ST - 1);
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
    chk(ev0 == 1'b1 && c0 == 5'd1, "R10", int'(ev0), 1);
    @(negedge clk);
    chk(ev0 == 1'b0 && n0 == b + 1, "R10", n0 - b, 1);
  endtask

  task automatic t_release;
    key_event(8'd243, 30, "R6");
  endtask

  task automatic t_windows;
    key_event(8'd0, 0, "R1");
    key_event(8'd29, 3, "R1");
    key_event(8'd236, 29, "R1");
    key_event(8'd254, 31, "R1");
  endtask

  task automatic t_invalid;
    int b = n0;
    settle(8'd15); ticks(40);
    settle(8'd5);  ticks(40);
    settle(8'd240); ticks(40);
    chk(n0 == b, "R2", n0 - b, 0);
  endtask

  task automatic t_inv_restart;
    int b;
    settle(8'd254); ticks(5);
    b = n0;
    settle(8'd12); ticks(10);
    settle(8'd15);
    settle(8'd12); ticks(ST - 1);
    chk(n0 == b, "R5", n0 - b, 0);
    ticks(1);
    chk(n0 == b + 1 && last0 == 5'd1, "R5", int'(last0), 1);
    b = n0;
    settle(8'd15); settle(8'd12); ticks(30);
    chk(n0 == b, "R5", n0 - b, 0);
  endtask

  task automatic t_chatter;
    int b = n0;
    settle(8'd20); ticks(10);
    for (int i = 0; i < CH - 1; i++) samp(8'd243);
    samp(8'd20);
    ticks(ST - 10 - 1);
    chk(n0 == b, "R4", n0 - b, 0);
    ticks(1);
    chk(n0 == b + 1 && last0 == 5'd2, "R4", int'(last0), 2);
  endtask

  task automatic t_shutdown;
    int b;
    settle(8'd28); ticks(10);
    b = n0;
    @(negedge clk); shutdown = 1'b1;
    ticks(20);
    settle(8'd28);
    chk(n0 == b && ev0 == 1'b0, "R8", n0 - b, 0);
    @(negedge clk); shutdown = 1'b0;
    key_event(8'd28, 3, "R9");
  endtask

  task automatic narrow(input logic [7:0] v, input int exp);
    int b = n1;
    settle(v);
    ticks(ST - 1);
    chk(n1 == b, "R7", n1 - b, 0);
    ticks(1);
    chk(n1 == b + 1 && last1 == 5'(exp), "R7", int'(last1), exp);
  endtask

  task automatic t_six;
    @(negedge clk); shutdown = 1'b1;
    @(negedge clk); shutdown = 1'b0;
    narrow(8'hF9, 1);
    narrow(8'h06, 30);
    narrow(8'hA7, 31);
    narrow(8'h05, 5);
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_pulse();
    t_release();
    t_windows();
    t_invalid();
    t_inv_restart();
    t_chatter();
    t_shutdown();
    t_six();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule